// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

This block is a small register window shared by a host processor and a firmware processor. The host first loads up to sixteen bytes of request payload into a write buffer. It then writes a command word. That write sets a busy flag and sends a one-cycle doorbell strobe to the firmware side. The firmware reads the latched command word and the payload through its own ports. It may place up to sixteen bytes of reply data into a read buffer. It finishes by pulsing a done strobe that carries an error flag and an 8-bit error code.

Completion clears busy and records the result in the status word. If the command word asked for a completion interrupt, completion also sets a sticky interrupt flag and sends the host a one-cycle interrupt pulse. The host can poll the status word or wait for that pulse. It clears the flag by writing a one to it.

The host port is a plain register port. A write takes effect on the clock edge where it is sampled. A read returns its data one cycle later, marked by a valid bit. Neither port applies back-pressure, and a request is never stalled. Firmware-side ports are plain strobes and index/data pairs.

Top module: `mbox_doorbell_top`

## Requirements
- R1: After reset the status word reads 0, the read buffer reads 0, the write buffer presents 0 on the firmware port, and the host interrupt and busy outputs are low.
- R2: A host write to offset 0x00 while idle sets busy and raises `fw_doorbell` for exactly one cycle. It also latches the word on `fw_cmd`. The status word then shows the sub-command id (command bits 15:12) in bits 7:4 and `host_id` in bits 15:8.
- R3: A command write while busy is dropped. There is no doorbell, and `fw_cmd` and the status word keep their values.
- R4: A `fw_done` pulse while busy clears busy. It loads status bit 1 with `fw_err` and status bits 23:16 with `fw_err_code`.
- R5: At completion, status bit 2 is set and `host_irq` pulses for exactly one cycle only when bit 8 of the starting command word was 1. Otherwise neither happens.
- R6: A host write to offset 0x04 with bit 2 set clears status bit 2. A write with bit 2 clear leaves it unchanged.
- R7: A host write to offset 0x80 + 4*i stores a 32-bit word that the firmware sees on `fw_wb_data` when `fw_wb_idx` = i. Host reads of 0x80–0x8F return 0.
- R8: A host read at offset 0x90 + n returns read-buffer word n/4 shifted right by 8*(n mod 4). The addressed byte therefore lands in bits 7:0.
- R9: A `fw_done` pulse while idle has no effect on the status word or `host_irq`.
- R10: An accepted command write clears the error bit and the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_id | input | 8 | Initiator id captured with each accepted command |
| host_rdata | output | 32 | Host read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| host_irq | output | 1 | One-cycle completion interrupt pulse |
| fw_doorbell | output | 1 | One-cycle doorbell pulse to firmware |
| fw_cmd | output | 32 | Latched command word |
| fw_busy | output | 1 | Command in flight |
| fw_wb_idx | input | 2 | Write-buffer word index |
| fw_wb_data | output | 32 | Write-buffer word at `fw_wb_idx` |
| fw_rb_we | input | 1 | Read-buffer word write strobe |
| fw_rb_idx | input | 2 | Read-buffer word index |
| fw_rb_data | input | 32 | Read-buffer write data |
| fw_done | input | 1 | Completion strobe |
| fw_err | input | 1 | Completion error flag |
| fw_err_code | input | 8 | Completion error code |

## Verification
The bench sends a second command while the first is still busy. A design that re-latches here would show a changed `fw_cmd`, a second doorbell, or the wrong command id in status. It also strobes done while idle, where a careless design would raise a stray interrupt or overwrite the stored error code. The interrupt is tested both with and without the request bit, and with write-zero and write-one to the flag, to catch an interrupt that ignores the request bit or a clear that is not write-one. Read-buffer reads at unaligned byte offsets expose a wrong shift. A new command that follows a failed one exposes stale error bits.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW        = 32;
  localparam int AW        = 8;
  localparam int BUF_BYTES = 16;
  localparam int BUF_WORDS = BUF_BYTES / (DW / 8);
  localparam int IW        = $clog2(BUF_WORDS);

  localparam logic [AW-1:0] OFF_CMD  = 8'h00;
  localparam logic [AW-1:0] OFF_STAT = 8'h04;
  localparam logic [3:0]    WIN_WB   = 4'h8;
  localparam logic [3:0]    WIN_RB   = 4'h9;

  localparam int CMD_IOC_BIT  = 8;
  localparam int STAT_IRQ_BIT = 2;

  typedef struct packed {
    logic [7:0] rsvd;
    logic [7:0] code;
    logic [7:0] initiator;
    logic [3:0] cmd_id;
    logic       rsvd3;
    logic       irq;
    logic       err;
    logic       busy;
  } status_t;
endpackage

// File: rtl/mbox_buf.sv
module mbox_buf #(
  parameter int WORDS = 4,
  parameter int W     = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                       mem[g] <= '0;
      else if (we && widx == IW'(g))    mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_data,
  input  logic [7:0]    host_id,
  input  logic          stat_wr,
  input  logic          stat_clr_bit,
  input  logic          done,
  input  logic          done_err,
  input  logic [7:0]    done_code,
  output logic          busy,
  output logic          doorbell,
  output logic [DW-1:0] cmd_q,
  output status_t       status,
  output logic          irq_pulse
);
  logic       err_q, irq_flag, ioc_q;
  logic [7:0] code_q, init_q;
  logic [3:0] cid_q;
  logic       accept, finish, irq_set, irq_clr;

  assign accept  = cmd_wr && !busy;
  assign finish  = done && busy;
  assign irq_set = finish && ioc_q;
  assign irq_clr = stat_wr && stat_clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      doorbell  <= 1'b0;
      irq_pulse <= 1'b0;
      err_q     <= 1'b0;
      irq_flag  <= 1'b0;
      ioc_q     <= 1'b0;
      code_q    <= '0;
      init_q    <= '0;
      cid_q     <= '0;
      cmd_q     <= '0;
    end else begin
      doorbell  <= accept;
      irq_pulse <= irq_set;
      if (accept) begin
        busy   <= 1'b1;
        cmd_q  <= cmd_data;
        ioc_q  <= cmd_data[CMD_IOC_BIT];
        cid_q  <= cmd_data[15:12];
        init_q <= host_id;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (finish) begin
        busy   <= 1'b0;
        err_q  <= done_err;
        code_q <= done_code;
      end
      if (irq_set)      irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status.busy      = busy;
    status.err       = err_q;
    status.irq       = irq_flag;
    status.cmd_id    = cid_q;
    status.initiator = init_q;
    status.code      = code_q;
  end

  AST_NO_RERING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> !doorbell); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R4
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy); // R4
  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !ioc_q) |=> !irq_pulse); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !status.irq); // R6
  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_wr) |=> $stable(code_q)); // R9
endmodule

// File: rtl/mbox_doorbell_top.sv
module mbox_doorbell_top
  import mbox_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_addr,
  input  logic [31:0]   host_wdata,
  input  logic [7:0]    host_id,
  output logic [31:0]   host_rdata,
  output logic          host_rvalid,
  output logic          host_irq,
  output logic          fw_doorbell,
  output logic [31:0]   fw_cmd,
  output logic          fw_busy,
  input  logic [1:0]    fw_wb_idx,
  output logic [31:0]   fw_wb_data,
  input  logic          fw_rb_we,
  input  logic [1:0]    fw_rb_idx,
  input  logic [31:0]   fw_rb_data,
  input  logic          fw_done,
  input  logic          fw_err,
  input  logic [7:0]    fw_err_code
);
  logic          cmd_wr, stat_wr, wb_we;
  logic [IW-1:0] win_idx;
  logic [DW-1:0] rb_word;
  status_t       status;

  assign win_idx = host_addr[IW+1:2];
  assign cmd_wr  = host_wr && host_addr == OFF_CMD;
  assign stat_wr = host_wr && host_addr == OFF_STAT;
  assign wb_we   = host_wr && host_addr[7:4] == WIN_WB;

  mbox_buf #(.WORDS(BUF_WORDS), .W(DW)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .we(wb_we), .widx(win_idx), .wdata(host_wdata),
    .ridx(fw_wb_idx), .rdata(fw_wb_data)
  );

  mbox_buf #(.WORDS(BUF_WORDS), .W(DW)) u_rbuf (
    .clk(clk), .rst_n(rst_n),
    .we(fw_rb_we), .widx(fw_rb_idx), .wdata(fw_rb_data),
    .ridx(win_idx), .rdata(rb_word)
  );

  mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_data(host_wdata), .host_id(host_id),
    .stat_wr(stat_wr), .stat_clr_bit(host_wdata[STAT_IRQ_BIT]),
    .done(fw_done), .done_err(fw_err), .done_code(fw_err_code),
    .busy(fw_busy), .doorbell(fw_doorbell), .cmd_q(fw_cmd),
    .status(status), .irq_pulse(host_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        if (host_addr == OFF_STAT)          host_rdata <= status;
        else if (host_addr[7:4] == WIN_RB)  host_rdata <= rb_word >> (8 * host_addr[1:0]);
        else                                host_rdata <= '0;
      end
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid); // R8
  AST_DOORBELL_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fw_doorbell |-> fw_busy); // R2
endmodule

// File: tb/tb_mbox_doorbell_top.sv
module tb_mbox_doorbell_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0]  host_id = 0;
  logic [31:0] host_rdata;
  logic        host_rvalid, host_irq, fw_doorbell, fw_busy;
  logic [31:0] fw_cmd, fw_wb_data;
  logic [1:0]  fw_wb_idx = 0, fw_rb_idx = 0;
  logic        fw_rb_we = 0, fw_done = 0, fw_err = 0;
  logic [31:0] fw_rb_data = 0;
  logic [7:0]  fw_err_code = 0;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mbox_doorbell_top dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected reads as the design returns them
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) check("READ_UNEXPECTED", host_rdata, 32'hx);
      else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk); host_rd = 1; host_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); host_rd = 0;
  endtask

  task automatic fwrb(logic [1:0] i, logic [31:0] d);
    @(negedge clk); fw_rb_we = 1; fw_rb_idx = i; fw_rb_data = d;
    @(negedge clk); fw_rb_we = 0;
  endtask

  // pulse done; returns irq seen in the cycle after the edge, and the cycle after that
  task automatic fwdone(logic e, logic [7:0] c, output logic irq1, output logic irq2);
    @(negedge clk); fw_done = 1; fw_err = e; fw_err_code = c;
    @(negedge clk); fw_done = 0; irq1 = host_irq;
    @(negedge clk); irq2 = host_irq;
  endtask

  initial begin
    logic i1, i2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, host_irq}, 0);
    check("R1 busy", {31'b0, fw_busy}, 0);
    check("R1 wbuf", fw_wb_data, 0);
    hread(8'h04, 32'h0, "R1 status");
    hread(8'h90, 32'h0, "R1 rbuf");

    // R7 write buffer
    for (int k = 0; k < 4; k++) hwrite(8'h80 + 8'(4*k), 32'hA0B0C000 + k);
    for (int k = 0; k < 4; k++) begin
      fw_wb_idx = 2'(k); #1;
      check("R7 wbuf word", fw_wb_data, 32'hA0B0C000 + k);
    end
    hread(8'h84, 32'h0, "R7 wbuf not readable");

    // R2 accepted command with completion request
    host_id = 8'hA7;
    @(negedge clk); host_wr = 1; host_addr = 8'h00; host_wdata = 32'h0003_5155;
    @(negedge clk); host_wr = 0;
    check("R2 doorbell", {31'b0, fw_doorbell}, 1);
    check("R2 cmd", fw_cmd, 32'h0003_5155);
    @(negedge clk);
    check("R2 doorbell one cycle", {31'b0, fw_doorbell}, 0);
    hread(8'h04, 32'h0000_A751, "R2 status");

    // R3 command while busy
    host_id = 8'h22;
    @(negedge clk); host_wr = 1; host_addr = 8'h00; host_wdata = 32'h0000_2077;
    @(negedge clk); host_wr = 0;
    check("R3 no doorbell", {31'b0, fw_doorbell}, 0);
    check("R3 cmd kept", fw_cmd, 32'h0003_5155);
    hread(8'h04, 32'h0000_A751, "R3 status kept");

    // R8 read buffer, byte offsets
    fwrb(0, 32'h4433_2211);
    fwrb(3, 32'hDDCC_BBAA);
    hread(8'h90, 32'h4433_2211, "R8 off0");
    hread(8'h91, 32'h0044_3322, "R8 off1");
    hread(8'h93, 32'h0000_0044, "R8 off3");
    hread(8'h9E, 32'h0000_DDCC, "R8 off14");

    // R4 R5 completion with error, interrupt requested
    fwdone(1'b1, 8'h3C, i1, i2);
    check("R5 irq pulse", {31'b0, i1}, 1);
    check("R5 irq one cycle", {31'b0, i2}, 0);
    check("R4 busy cleared", {31'b0, fw_busy}, 0);
    hread(8'h04, 32'h003C_A756, "R4 status");

    // R6 write-one-to-clear
    hwrite(8'h04, 32'h0000_0000);
    hread(8'h04, 32'h003C_A756, "R6 write zero keeps");
    hwrite(8'h04, 32'h0000_0004);
    hread(8'h04, 32'h003C_A752, "R6 write one clears");

    // R9 done while idle
    fwdone(1'b0, 8'h11, i1, i2);
    check("R9 no irq", {30'b0, i1, i2}, 0);
    hread(8'h04, 32'h003C_A752, "R9 status kept");

    // R10 new command clears error; R5 no request -> no interrupt
    host_id = 8'h5B;
    hwrite(8'h00, 32'h0000_1009);
    hread(8'h04, 32'h0000_5B11, "R10 error cleared");
    fwdone(1'b0, 8'h00, i1, i2);
    check("R5 no irq without request", {30'b0, i1, i2}, 0);
    hread(8'h04, 32'h0000_5B10, "R5 flag stays clear");

    repeat (4) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule